// File: doc/BRIEF.md
# Serial Clock Divider with Per-Select Mode

This block produces the serial clock of a quad-SPI style controller from a fast functional clock (nominally 192 MHz). A 32-bit clock-control word carries a run-enable flag in bit 31 and a 16-bit divide value in bits 15:0. The serial clock period is the divide value plus one functional cycles. A divide value of 0 cannot be met with registered logic, so it runs at the minimum ratio of two.

A packed device-control word gives each chip select its own byte. Within that byte, bit 0 is the clock polarity and bit 2 is the clock phase. The selected byte sets the resting level of the clock and decides which edge shifts data and which edge samples it. Two one-cycle strobes tell the transfer engine when a shift edge or a sample edge has just happened.

To change the rate, software clears the enable and then writes the new divide value with the enable set. A divide value is latched only when the divider starts from rest. When the divider is stopped, any active half-period that has begun is finished first, so the output never carries a runt pulse.

Top module: `qspi_sclk_gen`

## Requirements
- R1: While reset is asserted and directly after it, `sclk` equals the polarity bit of the selected chip select, and both strobes are low.
- R2: With divide value D latched, the serial clock period is D+1 functional cycles for D ≥ 1. D = 0 gives a period of 2 cycles.
- R3: Within each period of P cycles, `sclk` sits away from its resting level for floor(P/2) cycles.
- R4: After bit 31 of `clk_ctrl` rises at rest, `sclk` first leaves its resting level in the second functional cycle.
- R5: While the divider is at rest, `sclk` equals bit 8n+0 of `dev_ctrl`, where n is `cs_sel`.
- R6: Define leading as the edge leaving the resting level and trailing as the edge returning to it. With phase bit 8n+2 clear, `sample_stb` marks leading edges and `shift_stb` marks trailing edges. With the phase bit set, the two are swapped. Each strobe is high for the single cycle in which the new `sclk` level first appears.
- R7: When bit 31 is cleared, a started active half-period runs to its full length, and then `sclk` stays at rest with no further edges.
- R8: A divide value written while the enable stays set has no effect on the running clock. It takes effect only after the divider stops and is started again.
- R9: Bits 30:16 of `clk_ctrl` and bits 1 and 7:3 of every `dev_ctrl` byte have no effect on `sclk` or on the strobes. The bytes of unselected chip selects also have no effect.
- R10: `shift_stb` and `sample_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctrl | input | 32 | Enable in bit 31, divide value in bits 15:0 |
| dev_ctrl | input | 8*NUM_CS | One mode byte per chip select: polarity bit 0, phase bit 2 |
| cs_sel | input | CS_W | Index of the active chip select |
| sclk | output | 1 | Serial clock |
| shift_stb | output | 1 | One-cycle mark of a data-launch edge |
| sample_stb | output | 1 | One-cycle mark of a data-capture edge |

## Verification
The hardest case to reach is a disable that lands in the middle of an active half-period. Here the divider has to keep counting with the enable already low, finish the pulse, and only then fall silent. The bench drops the enable in the very cycle that the first leading edge shows. It then counts the remaining active cycles and checks that no edge follows. It also rewrites the divide value while the enable stays set, to confirm that the old period holds until the divider is restarted. A sweep over divide values, every chip select and all four polarity and phase pairs covers the rest. During that sweep the unselected bytes carry opposite settings and the ignored bits carry junk.

// File: rtl/qspi_sclk_gen.sv
module qspi_sclk_gen #(
  parameter int DIV_W  = 16,
  parameter int NUM_CS = 4,
  parameter int EN_BIT = 31,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           clk_ctrl,
  input  logic [8*NUM_CS-1:0]   dev_ctrl,
  input  logic [CS_W-1:0]       cs_sel,
  output logic                  sclk,
  output logic                  shift_stb,
  output logic                  sample_stb
);
  localparam int POL_BIT = 0;
  localparam int PHA_BIT = 2;

  logic             en;
  logic [DIV_W-1:0] div_in, div_q, cnt, deff, half;
  logic             run, act, lead_q, trail_q, lead_e, trail_e;
  logic [7:0]       mode;
  logic [DIV_W:0]   deff_p1;

  assign en      = clk_ctrl[EN_BIT];
  assign div_in  = clk_ctrl[DIV_W-1:0];
  assign mode    = dev_ctrl[8*cs_sel +: 8];
  assign deff    = (div_q == '0) ? DIV_W'(1) : div_q;
  assign deff_p1 = {1'b0, deff} + 1'b1;
  assign half    = deff_p1[DIV_W:1];
  assign lead_e  = run && en && !act && (cnt == '0);
  assign trail_e = run && act && (cnt == half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      act     <= 1'b0;
      cnt     <= '0;
      div_q   <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= lead_e;
      trail_q <= trail_e;
      if (!run) begin
        if (en) begin
          run   <= 1'b1;
          cnt   <= '0;
          div_q <= div_in;
        end
      end else if (!en && !act) begin
        run <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= (cnt == deff) ? '0 : cnt + 1'b1;
        if (lead_e)  act <= 1'b1;
        if (trail_e) act <= 1'b0;
      end
    end
  end

  assign sclk       = act ^ mode[POL_BIT];
  assign shift_stb  = mode[PHA_BIT] ? lead_q : trail_q;
  assign sample_stb = mode[PHA_BIT] ? trail_q : lead_q;

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_q, trail_q}));
  assert_rest_is_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !act);
  assert_divider_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(div_q));
  assert_strobe_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_q || trail_q) |-> (act != $past(act)));
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= deff));
  assert_finish_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act) |=> run);
endmodule

// File: tb/qspi_sclk_gen_tb.sv
module qspi_sclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] clk_ctrl = '0;
  logic [31:0] dev_ctrl = '0;
  logic [1:0]  cs_sel = '0;
  logic        sclk, shift_stb, sample_stb;
  int tests = 0, fails = 0, cycles = 0;

  qspi_sclk_gen dut_i (.clk(clk), .rst_n(rst_n), .clk_ctrl(clk_ctrl), .dev_ctrl(dev_ctrl),
    .cs_sel(cs_sel), .sclk(sclk), .shift_stb(shift_stb), .sample_stb(sample_stb));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input int cs, input bit pol, input bit pha);
    for (int i = 0; i < 4; i++)
      dev_ctrl[8*i +: 8] = (i == cs) ? {5'b10110, pha, 1'b1, pol} : {5'b01001, ~pha, 1'b0, ~pol};
    cs_sel = 2'(cs);
  endtask

  task automatic run_cfg(input int d, input int cs, input bit pol, input bit pha);
    int  p_exp, h_exp, per, hi;
    bit  bad, both, prev, lead, trail;
    p_exp = ((d == 0) ? 1 : d) + 1;
    h_exp = p_exp / 2;
    per = 0; hi = 1; bad = 0; both = 0;
    set_mode(cs, pol, pha);
    clk_ctrl = 32'h7ABC_0000 | 32'(d & 16'hFFFF);
    @(negedge clk);
    chk(sclk == pol, "R5", sclk, pol);
    clk_ctrl[31] = 1'b1;
    @(negedge clk);
    chk(sclk == pol, "R4 early", sclk, pol);
    @(negedge clk);
    chk(sclk != pol, "R4", sclk, !pol);
    if (shift_stb != pha || sample_stb != !pha) bad = 1;
    prev = sclk;
    for (int n = 1; n < 70000; n++) begin
      @(negedge clk);
      lead  = (prev == pol) && (sclk != pol);
      trail = (prev != pol) && (sclk == pol);
      if (shift_stb != (pha ? lead : trail) || sample_stb != (pha ? trail : lead)) bad = 1;
      if (shift_stb && sample_stb) both = 1;
      prev = sclk;
      if (lead) begin per = n; break; end
      if (sclk != pol) hi++;
    end
    chk(per == p_exp, "R2/R9 period", per, p_exp);
    chk(hi == h_exp, "R3 active time", hi, h_exp);
    chk(!bad, "R6 strobe mapping", bad, 0);
    chk(!both, "R10", both, 0);
    clk_ctrl[31] = 1'b0;
    repeat (h_exp + 4) @(negedge clk);
    chk(sclk == pol && !shift_stb && !sample_stb, "R5 rest after stop", sclk, pol);
  endtask

  task automatic period_now(input bit pol, output int per);
    bit prev, seen;
    per = -1; seen = 0;
    prev = sclk;
    for (int n = 1; n < 1000; n++) begin
      @(negedge clk);
      if (prev == pol && sclk != pol) begin
        if (seen) begin per = n; break; end
        seen = 1; n = 0;
      end
      prev = sclk;
    end
  endtask

  initial begin
    int act_cnt, leads, per;
    bit prev;
    set_mode(0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1 && !shift_stb && !sample_stb, "R1 in reset", sclk, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1 && !shift_stb && !sample_stb, "R1 after reset", sclk, 1);

    for (int d = 0; d <= 16; d++) run_cfg(d, d % 4, d[0], d[1]);
    for (int cs = 0; cs < 4; cs++)
      for (int m = 0; m < 4; m++) run_cfg(2, cs, m[0], m[1]);
    run_cfg(300, 1, 1'b0, 1'b1);
    run_cfg(16'hFFFF, 3, 1'b1, 1'b0);

    // R7: disable in the first active cycle
    set_mode(2, 1'b0, 1'b0);
    clk_ctrl = 32'h8000_0007;
    @(negedge clk); @(negedge clk);
    clk_ctrl[31] = 1'b0;
    act_cnt = (sclk != 1'b0) ? 1 : 0;
    leads = 0; prev = sclk;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (sclk != 1'b0) act_cnt++;
      if (prev == 1'b0 && sclk != 1'b0) leads++;
      prev = sclk;
    end
    chk(act_cnt == 4, "R7 pulse finished", act_cnt, 4);
    chk(leads == 0, "R7 no further edge", leads, 0);

    // R8: divide value rewritten while running
    set_mode(1, 1'b1, 1'b1);
    clk_ctrl = 32'h8000_0003;
    repeat (3) @(negedge clk);
    clk_ctrl = 32'h8000_0009;
    period_now(1'b1, per);
    chk(per == 4, "R8 old period kept", per, 4);
    clk_ctrl[31] = 1'b0;
    repeat (12) @(negedge clk);
    clk_ctrl[31] = 1'b1;
    period_now(1'b1, per);
    chk(per == 10, "R8 new period after restart", per, 10);
    clk_ctrl[31] = 1'b0;
    repeat (12) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule